// File: doc/BRIEF.md
# Three-Operand Ones' Complement Adder

This block adds two N-bit ones' complement words and a single unsigned carry bit, and reports signed overflow. A ones' complement word has no natural carry input. The carry bit is therefore added by a second ones' complement stage that is as wide as the whole word. That stage takes the first stage's result and a word whose least significant bit is the carry bit and whose other bits are zero.

Each stage works without a combinational loop. It forms x+y+0 and x+y+1 side by side. The carry out of x+y+0 then picks one of the two. This gives the end-around-carry result in one pass.

The result can leave the block straight from the adders, or through one pipeline register. A parameter selects between the two. Typical uses are checksum datapaths and ones' complement arithmetic units that need a carry input.

Top module: `oc_add3`

## Requirements
- R1: When the overflow flag is clear, the numeric value of `sum_o` equals value(a)+value(b)+cin. Here value(w) is w when w's top bit is 0 and −(~w) when it is 1, so all-zeros and all-ones both mean zero.
- R2: With `cin_i`=0, `sum_o` is bit for bit the two-operand ones' complement sum: t=a+b taken as unsigned, and if t ≥ 2^N the result is t−2^N+1.
- R3: When `b_i` is the bitwise complement of `a_i` and `cin_i`=0, `sum_o` is all ones (negative zero).
- R4: `ovf_o` is 1 exactly when one of these holds: p=value(a)+value(b) lies outside ±(2^(N−1)−1), or p is inside that range and p+cin exceeds 2^(N−1)−1.
- R5: With `cin_i`=1, `sum_o` is bit for bit the two-operand ones' complement sum (as in R2) of the R2 result and the value 1.
- R6: With OUT_REG=1, `sum_o` and `ovf_o` show the result for the inputs present at the previous rising clock edge. With OUT_REG=0 they follow the inputs within the same cycle.
- R7: With OUT_REG=1, while `rst` is high at a rising edge the outputs become `sum_o`=0 and `ovf_o`=0, whatever the inputs are.
- R8: Two positive zeros with `cin_i`=0 give all zeros. Two negative zeros with `cin_i`=0 give all ones. Two positive zeros with `cin_i`=1 give the value 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | WIDTH | First ones' complement operand |
| b_i | input | WIDTH | Second ones' complement operand |
| cin_i | input | 1 | Unsigned carry bit to add |
| sum_o | output | WIDTH | Ones' complement result |
| ovf_o | output | 1 | Signed overflow of either stage |

## Verification
A 4-bit build is swept over every pair of operands with both carry values. The sweep runs on a registered instance and on an unregistered instance at the same time. Operand pairs that are mutual complements separate the negative-zero result from the positive-zero result. Pairs with equal signs near the range limits separate true overflow from wrap-around. Cases where the first stage overflows but adding the carry returns to the range show that the overflow flag follows the two-stage definition rather than the final numeric value.

// File: rtl/oc_add_pkg.sv
package oc_add_pkg;

  // Signed overflow of a two-operand addition: the operand signs agree and
  // the sign of the result differs from them.
  function automatic logic sign_flip(input logic sx, input logic sy, input logic sr);
    return (sx == sy) && (sr != sx);
  endfunction

endpackage

// File: rtl/oc_bin_add.sv
module oc_bin_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  localparam int XW = W + 1;

  logic [XW-1:0] full;

  assign full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  assign s    = full[W-1:0];
  assign co   = full[XW-1];

endmodule

// File: rtl/oc_pair_add.sv
module oc_pair_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s,
  output logic         ovf
);
  import oc_add_pkg::*;

  localparam int NCAND = 2;

  logic [W-1:0] cand_s [NCAND];
  logic         cand_c [NCAND];

  // Two binary adders, carry-in tied to 0 and to 1: no loop back from the MSB.
  for (genvar k = 0; k < NCAND; k++) begin : g_cand
    oc_bin_add #(.W(W)) u_add (
      .x  (x),
      .y  (y),
      .ci (k[0]),
      .s  (cand_s[k]),
      .co (cand_c[k])
    );
  end

  // A carry out of x+y+0 means the end-around carry is 1.
  assign s   = cand_c[0] ? cand_s[1] : cand_s[0];
  assign ovf = sign_flip(x[W-1], y[W-1], s[W-1]);

  always_comb begin
    // R2
    if (cand_c[0]) begin
      c0_implies_c1_chk: assert (cand_c[1]);
    end
    // R3
    if (!cand_c[0] && cand_c[1]) begin
      ripple_all_ones_chk: assert (&cand_s[0]);
    end
  end

endmodule

// File: rtl/oc_add3.sv
module oc_add3 #(
  parameter int WIDTH   = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o
);

  localparam int UPPER = WIDTH - 1;

  logic [WIDTH-1:0] part_s;
  logic             part_ovf;
  logic [WIDTH-1:0] cin_word;
  logic [WIDTH-1:0] fin_s;
  logic             fin_ovf;
  logic             any_ovf;

  // Stage one: a + b with end-around carry.
  oc_pair_add #(.W(WIDTH)) u_stage_ab (
    .x   (a_i),
    .y   (b_i),
    .s   (part_s),
    .ovf (part_ovf)
  );

  // Stage two: full width, because the carry bit can ripple across the word.
  assign cin_word = {{UPPER{1'b0}}, cin_i};

  oc_pair_add #(.W(WIDTH)) u_stage_cin (
    .x   (part_s),
    .y   (cin_word),
    .s   (fin_s),
    .ovf (fin_ovf)
  );

  assign any_ovf = part_ovf | fin_ovf;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        sum_o <= '0;
        ovf_o <= 1'b0;
      end else begin
        sum_o <= fin_s;
        ovf_o <= any_ovf;
      end
    end

    // R3
    neg_zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
      (!cin_i && (b_i == ~a_i)) |=> (sum_o == '1));
    // R4
    mixed_sign_reg_chk: assert property (@(posedge clk) disable iff (rst)
      (!cin_i && (a_i[UPPER] != b_i[UPPER])) |=> !ovf_o);
    // R8
    pos_one_reg_chk: assert property (@(posedge clk) disable iff (rst)
      (cin_i && (a_i == '0) && (b_i == '0)) |=> (sum_o == {{UPPER{1'b0}}, 1'b1}));
    // R7
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> ((sum_o == '0) && !ovf_o));
  end else begin : g_comb
    assign sum_o = fin_s;
    assign ovf_o = any_ovf;

    // R3
    neg_zero_comb_chk: assert property (@(posedge clk) disable iff (rst)
      (!cin_i && (b_i == ~a_i)) |-> (sum_o == '1));
    // R4
    mixed_sign_comb_chk: assert property (@(posedge clk) disable iff (rst)
      (!cin_i && (a_i[UPPER] != b_i[UPPER])) |-> !ovf_o);
    // R8
    pos_one_comb_chk: assert property (@(posedge clk) disable iff (rst)
      (cin_i && (a_i == '0) && (b_i == '0)) |-> (sum_o == {{UPPER{1'b0}}, 1'b1}));
  end

endmodule

// File: tb/oc_add3_tb.sv
module oc_add3_tb;

  localparam int N    = 4;
  localparam int MOD  = 1 << N;
  localparam int MAXV = (1 << (N - 1)) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] a   = '0;
  logic [N-1:0] b   = '0;
  logic         cin = 1'b0;
  logic [N-1:0] sum_r, sum_c;
  logic         ovf_r, ovf_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  oc_add3 #(.WIDTH(N), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum_r), .ovf_o(ovf_r)
  );

  oc_add3 #(.WIDTH(N), .OUT_REG(1'b0)) u_dut_comb (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum_c), .ovf_o(ovf_c)
  );

  function automatic int val(input int w);
    return ((w >> (N - 1)) & 1) ? -((~w) & (MOD - 1)) : w;
  endfunction

  function automatic int oc2(input int x, input int y);
    int t;
    t = x + y;
    return (t >= MOD) ? (t - MOD + 1) : t;
  endfunction

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
               req, what, a, b, cin, act, exp);
    end
  endtask

  task automatic check_vec(input logic [N-1:0] s, input logic o, input string tag);
    int p, e_bits, e_ovf;
    p      = val(int'(a)) + val(int'(b));
    e_bits = cin ? oc2(oc2(int'(a), int'(b)), 1) : oc2(int'(a), int'(b));
    e_ovf  = ((p > MAXV) || (p < -MAXV) || (p + int'(cin) > MAXV)) ? 1 : 0;
    // R2 / R5: exact bits
    if (!cin) chk("R2", int'(s), e_bits, {tag, " bits"});
    else      chk("R5", int'(s), e_bits, {tag, " bits"});
    // R4: overflow flag
    chk("R4", int'(o), e_ovf, {tag, " ovf"});
    // R1: numeric value
    if (e_ovf == 0) chk("R1", val(int'(s)), p + int'(cin), {tag, " value"});
    // R3: complementary operands
    if (!cin && (b == ~a)) chk("R3", int'(s), MOD - 1, {tag, " negzero"});
    // R8: zero operands
    if (a == '0 && b == '0) chk("R8", int'(s), cin ? 1 : 0, {tag, " poszero"});
    if (a == '1 && b == '1 && !cin) chk("R8", int'(s), MOD - 1, {tag, " negzeros"});
  endtask

  initial begin
    a = 4'd5; b = 4'd6; cin = 1'b1;
    repeat (3) @(negedge clk);
    // R7: reset clears the registered outputs
    chk("R7", int'(sum_r), 0, "reset sum");
    chk("R7", int'(ovf_r), 0, "reset ovf");
    rst = 1'b0;
    for (int ia = 0; ia < MOD; ia++) begin
      for (int ib = 0; ib < MOD; ib++) begin
        for (int ic = 0; ic < 2; ic++) begin
          a = ia[N-1:0]; b = ib[N-1:0]; cin = ic[0];
          #1;
          check_vec(sum_c, ovf_c, "R6 comb");
          @(negedge clk);
          check_vec(sum_r, ovf_r, "R6 reg");
        end
      end
    end
    // R6: registered output holds until the next edge after an input change
    a = 4'd1; b = 4'd1; cin = 1'b0;
    @(negedge clk);
    a = 4'd2; b = 4'd2;
    #1;
    chk("R6", int'(sum_r), 2, "hold");
    @(negedge clk);
    chk("R6", int'(sum_r), 4, "update");
    // R7: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    chk("R7", int'(sum_r), 0, "rerst sum");
    chk("R7", int'(ovf_r), 0, "rerst ovf");
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule